// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side logic that decides what a parallel flash memory returns on status reads while an internal program or erase operation runs. It follows the multi-write command sequences arriving on the write bus and counts their bus cycles. From them it enters program, erase, erase-suspended or program-while-suspended operation. On every read strobe it registers a status byte whose polling bit (bit 7), read-toggle bit (bit 6) and sector-toggle bit (bit 2) follow the current mode. The toggle bits change once per read, not once per clock.

The block also drives the enable of an active-low open-drain ready/busy line. The board pull-up is outside the block, so `busy_pull_low = 1` means busy. A sector-match input tells the block whether the address being read lies in the sector under erase. An `op_done` strobe from an external timer ends the running operation. The memory array and the real program and erase durations are not modelled. In array-read mode a read returns no status, so `status_valid` is 0.

Top module: `flash_status_gen`

## Requirements
- R1: In program mode a read returns bit 7 = complement of bit 7 of the programmed data, bit 6 = 0 on the first read after the program starts and inverting on every later read, bit 2 = 1, all other bits 0 and `status_valid` = 1.
- R2: In erase mode a read returns bit 7 = 0 and bit 6 inverting on every read (0 first). For bit 2: a read with `rd_in_sector` = 1 returns a sector-toggle value that starts at 0 when the erase begins and inverts after each such read. A read with `rd_in_sector` = 0 returns bit 2 = 1 and leaves that value unchanged.
- R3: In erase-suspend mode, a read with `rd_in_sector` = 1 returns bit 7 = 1, bit 6 = 1 and bit 2 = the sector-toggle value, which keeps counting from the erase and then inverts. A read with `rd_in_sector` = 0 returns `status_valid` = 0 and status 0.
- R4: In program-while-suspended mode, reads return bit 7 = complement of the data bit 7 and bit 6 restarting at 0 and inverting per read. Bit 2 = 1 when `rd_in_sector` = 0; when `rd_in_sector` = 1, bit 2 is the continuing sector-toggle value.
- R5: Program sequence: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then any address with the data. Erase sequence: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then any address/0x30 or 0x555/0x10. A write that does not match the expected step, or data 0xF0 at any step except the program data step, returns the decoder to the first step.
- R6: `busy_pull_low` rises on the clock edge that takes the 4th write of a program sequence or the 6th write of an erase sequence, and not before.
- R7: While busy, every write is ignored, with one exception: data 0xB0 during an erase enters erase-suspend mode, and `busy_pull_low` falls on that edge.
- R8: In erase-suspend mode, data 0x30 as a first write resumes the erase (busy again, toggle values kept). A program sequence enters program-while-suspended mode (busy). An erase sequence is rejected.
- R9: `op_done` ends program or erase and returns to array read. It ends program-while-suspended and returns to erase-suspend. It has no effect in array read or erase-suspend. A write in the same cycle as `op_done` is discarded and does not advance the sequence.
- R10: `busy_pull_low` is 1 while `rst_n` is low. After reset the block is in array-read mode.
- R11: In array-read mode a read returns `status_valid` = 0 and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write bus cycle strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read bus cycle strobe |
| rd_in_sector | input | 1 | Read address lies in the sector under erase |
| op_done | input | 1 | Operation-complete strobe from the timer |
| status | output | 8 | Registered status byte of the last read |
| status_valid | output | 1 | Last read returned status bits |
| busy_pull_low | output | 1 | Open-drain enable, 1 = drive ready/busy low |

## Verification
A program run is started for all 256 data values. This separates the polling bit's dependence on data bit 7 from the fixed bit 2 and the per-read toggle. Erase runs use all sixteen in/out-of-sector patterns over four reads, alternating the two erase confirm forms. These patterns show that bit 6 advances on every read while bit 2 advances only on in-sector reads. Directed flows cover suspend, program while suspended, resume, and writes ignored while busy. They also cover aborted and misaddressed sequences, `op_done` colliding with a write, and reset in the middle of an operation; these tell apart the mode returned to and the busy edge position.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int unsigned DQ_W      = 8;
  localparam int unsigned DQ_POLL   = 7;
  localparam int unsigned DQ_TOGGLE = 6;
  localparam int unsigned DQ_SECTOR = 2;

  localparam logic [DQ_W-1:0] CMD_UNLOCK1  = 8'hAA;
  localparam logic [DQ_W-1:0] CMD_UNLOCK2  = 8'h55;
  localparam logic [DQ_W-1:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [DQ_W-1:0] CMD_ERASE_SU = 8'h80;
  localparam logic [DQ_W-1:0] CMD_SECT_ERS = 8'h30;
  localparam logic [DQ_W-1:0] CMD_CHIP_ERS = 8'h10;
  localparam logic [DQ_W-1:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [DQ_W-1:0] CMD_RESUME   = 8'h30;
  localparam logic [DQ_W-1:0] CMD_ABORT    = 8'hF0;

  typedef enum logic [2:0] {
    MODE_READ      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP      = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } fsg_mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_KEY2  = 3'd1,
    SEQ_OPSEL = 3'd2,
    SEQ_PDATA = 3'd3,
    SEQ_EKEY1 = 3'd4,
    SEQ_EKEY2 = 3'd5,
    SEQ_ECONF = 3'd6
  } fsg_seq_e;

  typedef struct packed {
    logic prog_go;
    logic erase_go;
    logic suspend;
    logic resume;
  } fsg_cmd_t;

  function automatic logic mode_busy(fsg_mode_e m);
    return (m == MODE_PROG) || (m == MODE_ERASE) || (m == MODE_SUSP_PROG);
  endfunction

endpackage

// File: rtl/fsg_cmd_decode.sv
module fsg_cmd_decode
  import fsg_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 12'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fsg_mode_e         mode_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DQ_W-1:0]   wr_data_i,
  input  logic              op_done_i,
  output fsg_cmd_t          cmd_o
);

  fsg_seq_e step_q, step_nx;
  logic     seq_en;
  logic     wr_take;
  logic     at_a, at_b;

  always_comb begin
    seq_en  = (mode_i == MODE_READ) || (mode_i == MODE_SUSP);
    wr_take = wr_stb_i && !op_done_i;
    at_a    = (wr_addr_i == UNLOCK_A);
    at_b    = (wr_addr_i == UNLOCK_B);
    step_nx = step_q;
    cmd_o   = '0;
    if (!seq_en) begin
      step_nx = SEQ_IDLE;
    end
    if (wr_take) begin
      if (mode_i == MODE_ERASE && wr_data_i == CMD_SUSPEND) begin
        cmd_o.suspend = 1'b1;
      end else if (seq_en) begin
        if (step_q == SEQ_PDATA) begin
          cmd_o.prog_go = 1'b1;
          step_nx       = SEQ_IDLE;
        end else if (wr_data_i == CMD_ABORT) begin
          step_nx = SEQ_IDLE;
        end else begin
          step_nx = SEQ_IDLE;
          case (step_q)
            SEQ_IDLE: begin
              if (mode_i == MODE_SUSP && wr_data_i == CMD_RESUME) begin
                cmd_o.resume = 1'b1;
              end else if (at_a && wr_data_i == CMD_UNLOCK1) begin
                step_nx = SEQ_KEY2;
              end
            end
            SEQ_KEY2: begin
              if (at_b && wr_data_i == CMD_UNLOCK2) step_nx = SEQ_OPSEL;
            end
            SEQ_OPSEL: begin
              if (at_a && wr_data_i == CMD_PROGRAM) begin
                step_nx = SEQ_PDATA;
              end else if (at_a && wr_data_i == CMD_ERASE_SU && mode_i == MODE_READ) begin
                step_nx = SEQ_EKEY1;
              end
            end
            SEQ_EKEY1: begin
              if (at_a && wr_data_i == CMD_UNLOCK1) step_nx = SEQ_EKEY2;
            end
            SEQ_EKEY2: begin
              if (at_b && wr_data_i == CMD_UNLOCK2) step_nx = SEQ_ECONF;
            end
            SEQ_ECONF: begin
              if (wr_data_i == CMD_SECT_ERS || (at_a && wr_data_i == CMD_CHIP_ERS)) begin
                cmd_o.erase_go = 1'b1;
              end
            end
            default: step_nx = SEQ_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= SEQ_IDLE;
    end else begin
      step_q <= step_nx;
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd_o)); // R5
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n) mode_busy(mode_i) |-> !(cmd_o.prog_go || cmd_o.erase_go || cmd_o.resume)); // R7
  AST_DONE_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) op_done_i |-> (cmd_o == '0)); // R9
  AST_SEQ_CLEARED_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mode_busy(mode_i) |=> (step_q == SEQ_IDLE)); // R7

endmodule

// File: rtl/fsg_mode_ctl.sv
module fsg_mode_ctl
  import fsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fsg_cmd_t  cmd_i,
  input  logic      op_done_i,
  output fsg_mode_e mode_o,
  output logic      busy_o
);

  fsg_mode_e mode_q, mode_nx;

  always_comb begin
    mode_nx = mode_q;
    case (mode_q)
      MODE_READ: begin
        if (cmd_i.prog_go)       mode_nx = MODE_PROG;
        else if (cmd_i.erase_go) mode_nx = MODE_ERASE;
      end
      MODE_PROG: begin
        if (op_done_i) mode_nx = MODE_READ;
      end
      MODE_ERASE: begin
        if (op_done_i)          mode_nx = MODE_READ;
        else if (cmd_i.suspend) mode_nx = MODE_SUSP;
      end
      MODE_SUSP: begin
        if (cmd_i.prog_go)     mode_nx = MODE_SUSP_PROG;
        else if (cmd_i.resume) mode_nx = MODE_ERASE;
      end
      MODE_SUSP_PROG: begin
        if (op_done_i) mode_nx = MODE_SUSP;
      end
      default: mode_nx = MODE_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
    end else begin
      mode_q <= mode_nx;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = mode_busy(mode_q);

  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_READ && cmd_i.prog_go) |=> busy_o); // R6
  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_READ && cmd_i.erase_go) |=> busy_o); // R6
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_READ && !cmd_i.prog_go && !cmd_i.erase_go) |=> !busy_o); // R6
  AST_SUSPEND_FREE: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_ERASE && cmd_i.suspend && !op_done_i) |=> !busy_o); // R7
  AST_DONE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n) ((mode_q == MODE_PROG || mode_q == MODE_ERASE) && op_done_i) |=> (mode_q == MODE_READ)); // R9
  AST_DONE_TO_SUSP: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_SUSP_PROG && op_done_i) |=> (mode_q == MODE_SUSP)); // R9

endmodule

// File: rtl/fsg_status_gen.sv
module fsg_status_gen
  import fsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  fsg_mode_e       mode_i,
  input  fsg_cmd_t        cmd_i,
  input  logic            prog_bit_i,
  input  logic            rd_stb_i,
  input  logic            rd_in_sector_i,
  output logic [DQ_W-1:0] status_o,
  output logic            valid_o
);

  logic            tog6_q, tog6_nx;
  logic            tog2_q, tog2_nx;
  logic            pbit_q, pbit_nx;
  logic [DQ_W-1:0] stat_q, stat_nx;
  logic            valid_q, valid_nx;

  always_comb begin
    tog6_nx  = tog6_q;
    tog2_nx  = tog2_q;
    pbit_nx  = pbit_q;
    stat_nx  = stat_q;
    valid_nx = valid_q;
    if (rd_stb_i) begin
      stat_nx  = '0;
      valid_nx = 1'b0;
      case (mode_i)
        MODE_PROG: begin
          valid_nx            = 1'b1;
          stat_nx[DQ_POLL]    = ~pbit_q;
          stat_nx[DQ_TOGGLE]  = tog6_q;
          stat_nx[DQ_SECTOR]  = 1'b1;
          tog6_nx             = ~tog6_q;
        end
        MODE_ERASE: begin
          valid_nx            = 1'b1;
          stat_nx[DQ_TOGGLE]  = tog6_q;
          tog6_nx             = ~tog6_q;
          if (rd_in_sector_i) begin
            stat_nx[DQ_SECTOR] = tog2_q;
            tog2_nx            = ~tog2_q;
          end else begin
            stat_nx[DQ_SECTOR] = 1'b1;
          end
        end
        MODE_SUSP: begin
          if (rd_in_sector_i) begin
            valid_nx           = 1'b1;
            stat_nx[DQ_POLL]   = 1'b1;
            stat_nx[DQ_TOGGLE] = 1'b1;
            stat_nx[DQ_SECTOR] = tog2_q;
            tog2_nx            = ~tog2_q;
          end
        end
        MODE_SUSP_PROG: begin
          valid_nx            = 1'b1;
          stat_nx[DQ_POLL]    = ~pbit_q;
          stat_nx[DQ_TOGGLE]  = tog6_q;
          tog6_nx             = ~tog6_q;
          if (rd_in_sector_i) begin
            stat_nx[DQ_SECTOR] = tog2_q;
            tog2_nx            = ~tog2_q;
          end else begin
            stat_nx[DQ_SECTOR] = 1'b1;
          end
        end
        default: begin
          valid_nx = 1'b0;
        end
      endcase
    end
    if (cmd_i.prog_go) begin
      pbit_nx = prog_bit_i;
      tog6_nx = 1'b0;
    end
    if (cmd_i.erase_go) begin
      tog6_nx = 1'b0;
      tog2_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6_q  <= 1'b0;
      tog2_q  <= 1'b0;
      pbit_q  <= 1'b0;
      stat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      tog6_q  <= tog6_nx;
      tog2_q  <= tog2_nx;
      pbit_q  <= pbit_nx;
      stat_q  <= stat_nx;
      valid_q <= valid_nx;
    end
  end

  assign status_o = stat_q;
  assign valid_o  = valid_q;

  AST_PROG_SECTOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_PROG) |=> (valid_o && status_o[DQ_SECTOR])); // R1
  AST_PROG_TOGGLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_PROG && $past(rd_stb_i) && $past(mode_i) == MODE_PROG) |=> (status_o[DQ_TOGGLE] != $past(status_o[DQ_TOGGLE]))); // R1
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_ERASE) |=> (valid_o && !status_o[DQ_POLL])); // R2
  AST_ERASE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_ERASE && !rd_in_sector_i) |=> status_o[DQ_SECTOR]); // R2
  AST_SUSP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_SUSP && rd_in_sector_i) |=> (status_o[DQ_POLL] && status_o[DQ_TOGGLE])); // R3
  AST_SUSP_ARRAY: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_SUSP && !rd_in_sector_i) |=> !valid_o); // R3
  AST_SPROG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_SUSP_PROG && !rd_in_sector_i) |=> status_o[DQ_SECTOR]); // R4
  AST_READ_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb_i && mode_i == MODE_READ) |=> (!valid_o && status_o == '0)); // R11
  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd_stb_i |=> $stable(status_o)); // R1

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 12'h2AA,
  parameter int unsigned       SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_stb,
  input  logic              rd_in_sector,
  input  logic              op_done,
  output logic [7:0]        status,
  output logic              status_valid,
  output logic              busy_pull_low
);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  fsg_cmd_t            cmd;
  fsg_mode_e           mode;
  logic                op_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  fsg_cmd_decode #(
    .ADDR_W   (ADDR_W),
    .UNLOCK_A (UNLOCK_A),
    .UNLOCK_B (UNLOCK_B)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_i    (mode),
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .op_done_i (op_done),
    .cmd_o     (cmd)
  );

  fsg_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_i     (cmd),
    .op_done_i (op_done),
    .mode_o    (mode),
    .busy_o    (op_busy)
  );

  fsg_status_gen u_status (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .mode_i         (mode),
    .cmd_i          (cmd),
    .prog_bit_i     (wr_data[DQ_POLL]),
    .rd_stb_i       (rd_stb),
    .rd_in_sector_i (rd_in_sector),
    .status_o       (status),
    .valid_o        (status_valid)
  );

  assign busy_pull_low = !rst_int_n || op_busy;

  AST_BUSY_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_int_n) busy_pull_low |-> mode_busy(mode)); // R10

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

  localparam int B_READ = 0, B_PROG = 1, B_ERASE = 2, B_SUSP = 3, B_SPROG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_stb = 1'b0;
  logic        rd_in_sector = 1'b0;
  logic        op_done = 1'b0;
  logic [7:0]  status;
  logic        status_valid;
  logic        busy_pull_low;

  int n_cmp = 0;
  int n_bad = 0;
  int m_mode = B_READ;
  logic m_tog6 = 1'b0, m_tog2 = 1'b0, m_d7 = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_gen u_flash_status_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_stb        (rd_stb),
    .rd_in_sector  (rd_in_sector),
    .op_done       (op_done),
    .status        (status),
    .status_valid  (status_valid),
    .busy_pull_low (busy_pull_low)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic in_sec);
    logic [7:0] es;
    logic       ev;
    es = '0; ev = 1'b0;
    case (m_mode)
      B_PROG: begin ev = 1; es[7] = ~m_d7; es[6] = m_tog6; es[2] = 1; m_tog6 = ~m_tog6; end
      B_ERASE: begin
        ev = 1; es[6] = m_tog6; m_tog6 = ~m_tog6;
        if (in_sec) begin es[2] = m_tog2; m_tog2 = ~m_tog2; end else es[2] = 1;
      end
      B_SUSP: if (in_sec) begin ev = 1; es[7] = 1; es[6] = 1; es[2] = m_tog2; m_tog2 = ~m_tog2; end
      B_SPROG: begin
        ev = 1; es[7] = ~m_d7; es[6] = m_tog6; m_tog6 = ~m_tog6;
        if (in_sec) begin es[2] = m_tog2; m_tog2 = ~m_tog2; end else es[2] = 1;
      end
      default: ;
    endcase
    @(negedge clk);
    rd_stb = 1'b1; rd_in_sector = in_sec;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(tag, {23'd0, status_valid, status}, {23'd0, ev, es});
  endtask

  task automatic erase_head();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic start_prog(input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h3C1, d);
    if (m_mode == B_READ) m_mode = B_PROG; else m_mode = B_SPROG;
    m_d7 = d[7]; m_tog6 = 1'b0;
  endtask

  task automatic start_erase();
    erase_head(); wr(12'h0F0, 8'h30);
    m_mode = B_ERASE; m_tog6 = 1'b0; m_tog2 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10: busy held during reset, read mode after release
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy_pull_low, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", busy_pull_low, 0);
    rd_chk("R11 read mode status", 1'b1);

    // R1 R6: program over every data value
    for (int v = 0; v < 256; v++) begin
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
      chk("R6 not busy before 4th write", busy_pull_low, 0);
      wr(12'h3C1, v[7:0]);
      m_mode = B_PROG; m_d7 = v[7]; m_tog6 = 1'b0;
      chk("R6 busy after 4th write", busy_pull_low, 1);
      for (int k = 0; k < 4; k++) rd_chk("R1 program status", v[k]);
      done_pulse(); m_mode = B_READ;
      chk("R9 program done", busy_pull_low, 0);
      if (v % 32 == 0) rd_chk("R11 read after program", 1'b1);
    end

    // R2 R5 R6: erase over all in/out-of-sector read patterns
    for (int p = 0; p < 16; p++) begin
      erase_head();
      chk("R6 not busy before 6th write", busy_pull_low, 0);
      if (p[0]) wr(12'h555, 8'h10); else wr(12'h111, 8'h30);
      m_mode = B_ERASE; m_tog6 = 1'b0; m_tog2 = 1'b0;
      chk("R6 busy after 6th write", busy_pull_low, 1);
      for (int k = 0; k < 4; k++) rd_chk("R2 erase status", p[k]);
      done_pulse(); m_mode = B_READ;
      chk("R9 erase done", busy_pull_low, 0);
    end

    // R7: writes ignored while programming
    start_prog(8'h00);
    rd_chk("R1 program first read", 1'b0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h3C1, 8'h80);
    wr(12'h000, 8'hB0);
    chk("R7 busy kept in program", busy_pull_low, 1);
    rd_chk("R7 program data not replaced", 1'b0);
    done_pulse(); m_mode = B_READ;

    // R7 R3: erase ignores program, suspend frees busy
    start_erase();
    rd_chk("R2 erase in sector", 1'b1);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h3C1, 8'h00);
    chk("R7 busy kept in erase", busy_pull_low, 1);
    rd_chk("R7 erase status unchanged", 1'b0);
    wr(12'h7FF, 8'hB0); m_mode = B_SUSP;
    chk("R7 suspend releases busy", busy_pull_low, 0);
    rd_chk("R3 suspend in sector", 1'b1);
    rd_chk("R3 suspend in sector again", 1'b1);
    rd_chk("R3 suspend other sector", 1'b0);

    // R8: erase sequence rejected in suspend
    erase_head(); wr(12'h0F0, 8'h30);
    chk("R8 erase rejected in suspend", busy_pull_low, 0);
    rd_chk("R8 still suspended", 1'b1);

    // R9: op_done ignored in suspend
    done_pulse();
    rd_chk("R9 done ignored in suspend", 1'b1);

    // R4 R8: program while suspended
    start_prog(8'h80);
    chk("R8 busy in suspend program", busy_pull_low, 1);
    rd_chk("R4 suspend program outside", 1'b0);
    rd_chk("R4 suspend program inside", 1'b1);
    rd_chk("R4 suspend program outside 2", 1'b0);
    done_pulse(); m_mode = B_SUSP;
    chk("R9 suspend program done", busy_pull_low, 0);
    rd_chk("R9 back to suspend", 1'b1);
    wr(12'h222, 8'h30); m_mode = B_ERASE;
    chk("R8 resume busy", busy_pull_low, 1);
    rd_chk("R8 resumed erase", 1'b1);
    rd_chk("R8 resumed erase 2", 1'b0);
    done_pulse(); m_mode = B_READ;

    // R9: op_done in read mode
    done_pulse();
    chk("R9 done in read", busy_pull_low, 0);
    rd_chk("R11 read mode after stray done", 1'b0);

    // R9: write colliding with op_done is dropped, position kept
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 12'h3C1; wr_data = 8'h00; op_done = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; op_done = 1'b0;
    chk("R9 colliding write dropped", busy_pull_low, 0);
    wr(12'h3C1, 8'hFF); m_mode = B_PROG; m_d7 = 1'b1; m_tog6 = 1'b0;
    chk("R9 sequence position kept", busy_pull_low, 1);
    rd_chk("R1 program with F0-range data", 1'b0);
    done_pulse(); m_mode = B_READ;

    // R5: aborted and misaddressed sequences
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hF0);
    wr(12'h555, 8'hA0); wr(12'h3C1, 8'h12);
    chk("R5 abort clears sequence", busy_pull_low, 0);
    wr(12'h555, 8'hAA); wr(12'h555, 8'h55); wr(12'h555, 8'hA0); wr(12'h3C1, 8'h12);
    chk("R5 wrong unlock address", busy_pull_low, 0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h123, 8'h10);
    chk("R5 chip erase needs unlock address", busy_pull_low, 0);
    rd_chk("R11 no status after bad sequences", 1'b1);

    // R10: reset during program
    start_prog(8'h40);
    chk("R6 busy before reset", busy_pull_low, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 busy during reset", busy_pull_low, 1);
    repeat (3) @(negedge clk);
    chk("R10 busy held in reset", busy_pull_low, 1);
    rst_n = 1'b1; m_mode = B_READ;
    repeat (4) @(negedge clk);
    chk("R10 released after reset", busy_pull_low, 0);
    rd_chk("R10 read mode after reset", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule